// File: doc/BRIEF.md
# Track-Linked Instruction Sequencer

This unit sits between an instruction store and an execution core and takes over the program-counter function. Code is held in fixed-size physical tracks. An instruction address is a track number followed by a slot offset inside that track. The sequencer walks through a track one slot at a time. At the last slot it follows a next-track link that a per-track header supplies. Jumps have one encoding only, and the sequencer resolves them itself. A jump word is never handed to the core. The word delivered after it is always the correct continuation, so the core never flushes and has no delay slot.

Calls, returns, traps and interrupts all pass through one link register. A jump with its save bit set writes the address that follows the jump into that register. A return is a jump whose target comes from that register. Software must spill the register when calls nest. A trap or an accepted interrupt also loads the register and then redirects the stream to a fixed vector. The core takes words through a valid/ready handshake. The instruction store and the header store are read combinationally, using addresses the unit drives.

Top module: `track_seq`

## Requirements
- R1: After reset the current address is track BOOT_TRK, slot 0. That word is offered at once, with out_valid high, provided it is not a jump.
- R2: When a word is accepted (out_valid and out_ready both high) from a slot below the last one, the next address is the same track with the slot plus one.
- R3: When a word is accepted from the last slot of a track, the next address is slot 0 of the track that hdr_link returns for the current track.
- R4: A word with bit 15 set is a jump. It is never offered on the output. The address field in bits 6:0 (track in bits 6:3, slot in bits 2:0) gives the next address when the jump is taken.
- R5: Bit 13 of a jump makes it conditional. A conditional jump is taken only when cc equals bit 12. When it is not taken, the stream continues at the sequential successor of the jump.
- R6: A taken jump with bit 14 set stores the sequential successor of the jump in the link register. A jump with bit 11 set uses the link register as its target in place of bits 6:0.
- R7: When trap_req is high, out_valid is low in that cycle. The current address goes into the link register, and the next address is TRAP_VEC.
- R8: An interrupt is taken only in a cycle where a word is accepted. The successor of that word goes into the link register and the next address is IRQ_VEC. A trap in the same cycle wins, and no interrupt is taken.
- R9: While out_valid is high and out_ready is low, with no trap, the offered word and address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 7 | Instruction store read address {track, slot} |
| imem_data | input | 16 | Instruction word at imem_addr |
| hdr_track | output | 4 | Track whose header is read |
| hdr_link | input | 4 | Next-track link from that header |
| cc | input | 1 | Condition code prepared by earlier instructions |
| trap_req | input | 1 | Trap request |
| irq_req | input | 1 | Interrupt request |
| out_valid | output | 1 | Instruction offered to the core |
| out_ready | input | 1 | Core accepts the offered instruction |
| out_instr | output | 16 | Offered instruction word |
| out_addr | output | 7 | Address of the current word |

## Verification
The assertions take it for granted that the instruction store and the header store are static and answer within the same cycle. The stall and step properties rely on that. They also assume that cc changes only between jumps, and that a trap request may arrive in any cycle. The stimulus loads both stores before reset is released and never writes them afterwards. It keeps cc fixed, and it drives the requests only while the output is frozen or during a single accepted word. The redirect cycles can therefore be predicted exactly.

// File: rtl/track_seq.sv
module track_seq #(
  parameter int TW = 4,
  parameter int OW = 3,
  parameter int IW = 16,
  parameter int BOOT_TRK = 0,
  parameter int TRAP_VEC = 7'h70,
  parameter int IRQ_VEC = 7'h78
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW+OW-1:0] imem_addr,
  input  logic [IW-1:0] imem_data,
  output logic [TW-1:0] hdr_track,
  input  logic [TW-1:0] hdr_link,
  input  logic          cc,
  input  logic          trap_req,
  input  logic          irq_req,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_instr,
  output logic [TW+OW-1:0] out_addr
);
  localparam int AW = TW + OW;
  localparam int JB = IW - 1;
  localparam int SB = IW - 2;
  localparam int CB = IW - 3;
  localparam int PB = IW - 4;
  localparam int RB = IW - 5;
  localparam logic [OW-1:0] LAST = {OW{1'b1}};

  logic [AW-1:0] pc, jtar, succ, tgt;
  logic is_jump, taken, fire, irq_take;

  assign imem_addr = pc;
  assign hdr_track = pc[AW-1:OW];
  assign succ      = (pc[OW-1:0] == LAST) ? {hdr_link, {OW{1'b0}}} : pc + AW'(1);
  assign is_jump   = imem_data[JB];
  assign taken     = !imem_data[CB] || (cc == imem_data[PB]);
  assign tgt       = imem_data[RB] ? jtar : imem_data[AW-1:0];
  assign out_valid = !trap_req && !is_jump;
  assign out_instr = imem_data;
  assign out_addr  = pc;
  assign fire      = out_valid && out_ready;
  assign irq_take  = fire && irq_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc   <= {TW'(BOOT_TRK), {OW{1'b0}}};
      jtar <= '0;
    end else if (trap_req) begin
      jtar <= pc;
      pc   <= AW'(TRAP_VEC);
    end else if (irq_take) begin
      jtar <= succ;
      pc   <= AW'(IRQ_VEC);
    end else if (fire) begin
      pc <= succ;
    end else if (is_jump) begin
      if (taken) begin
        pc <= tgt;
        if (imem_data[SB]) jtar <= succ;
      end else begin
        pc <= succ;
      end
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !irq_req && pc[OW-1:0] != LAST |=> out_addr == $past(out_addr) + AW'(1));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !irq_req && pc[OW-1:0] == LAST |=>
      out_addr[OW-1:0] == '0 && out_addr[AW-1:OW] == $past(hdr_link));

  assert_trap_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> out_addr == AW'(TRAP_VEC));

  assert_trap_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> jtar == $past(out_addr));

  assert_irq_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && irq_req |=> out_addr == AW'(IRQ_VEC));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> trap_req || (out_valid && $stable(out_addr)));
endmodule

// File: tb/tb_track_seq.sv
module tb_track_seq;
  logic clk = 0, rst_n = 0;
  logic [6:0] imem_addr, out_addr;
  logic [15:0] imem_data, out_instr;
  logic [3:0] hdr_track, hdr_link;
  logic cc = 0, trap_req = 0, irq_req = 0, out_ready = 0, out_valid;

  logic [15:0] mem [128];
  logic [3:0] hdr [16];
  typedef struct { logic [6:0] a; string r; } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  assign imem_data = mem[imem_addr];
  assign hdr_link  = hdr[hdr_track];

  track_seq dut (.clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .hdr_track(hdr_track), .hdr_link(hdr_link), .cc(cc), .trap_req(trap_req),
    .irq_req(irq_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_instr(out_instr), .out_addr(out_addr));

  function automatic logic [15:0] jw(bit s, bit c, bit p, bit r, logic [6:0] t);
    return {1'b1, s, c, p, r, 4'b0, t};
  endfunction

  function automatic logic [6:0] succ_of(logic [6:0] a);
    return (a[2:0] == 3'd7) ? {hdr[a[6:3]], 3'd0} : a + 7'd1;
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic push(logic [6:0] a, string r);
    exp_t e;
    e.a = a; e.r = r;
    q.push_back(e);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #5;
  endtask

  always begin
    @(negedge clk);
    #5;
    if (rst_n && out_valid && out_ready && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(out_addr == e.a, e.r, out_addr, e.a);
      chk(out_instr == mem[e.a], e.r, out_instr, mem[e.a]);
    end
  end

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [6:0] a;
    for (int i = 0; i < 128; i++) mem[i] = 16'h1000 | 16'(i);
    for (int t = 0; t < 16; t++) hdr[t] = 4'(t + 1);
    hdr[0] = 4'd3;
    mem[7'h19] = jw(0, 0, 0, 0, 7'h28);
    mem[7'h29] = jw(0, 1, 1, 0, 7'h30);
    mem[7'h2B] = jw(0, 1, 0, 0, 7'h30);
    mem[7'h31] = jw(1, 0, 0, 0, 7'h40);
    mem[7'h41] = jw(0, 0, 0, 1, 7'h00);
    mem[7'h33] = jw(0, 0, 0, 0, 7'h50);
    mem[7'h70] = jw(0, 0, 0, 1, 7'h00);
    mem[7'h79] = jw(0, 0, 0, 1, 7'h00);

    repeat (3) step();
    rst_n = 1;
    settle();
    chk(out_addr == 7'h00, "R1", out_addr, 0);
    chk(out_valid == 1'b1, "R1", out_valid, 1);

    for (int i = 0; i < 8; i++) push(7'(i), "R2");
    push(7'h18, "R3");
    push(7'h28, "R4");
    push(7'h2A, "R5");
    push(7'h30, "R5");
    push(7'h40, "R6");
    push(7'h32, "R6");
    push(7'h50, "R4");
    step();
    out_ready = 1;
    repeat (4) step();
    out_ready = 0;
    settle();
    a = out_addr;
    for (int i = 0; i < 3; i++) begin
      step(); settle();
      chk(out_addr == a && out_valid, "R9", out_addr, a);
    end
    step();
    out_ready = 1;
    wait (q.size() == 0);
    step();
    out_ready = 0;
    settle();
    a = out_addr;

    step();
    trap_req = 1;
    settle();
    chk(out_valid == 1'b0, "R7", out_valid, 0);
    step();
    trap_req = 0;
    settle();
    chk(out_addr == 7'h70, "R7", out_addr, 7'h70);
    step(); settle();
    chk(out_addr == a && out_valid, "R7", out_addr, a);

    step();
    irq_req = 1;
    for (int i = 0; i < 2; i++) begin
      step(); settle();
      chk(out_addr == a, "R8", out_addr, a);
    end
    push(a, "R8");
    push(7'h78, "R8");
    push(succ_of(a), "R6");
    step();
    out_ready = 1;
    step();
    irq_req = 0;
    wait (q.size() == 0);
    step();
    out_ready = 0;
    settle();
    a = out_addr;

    step();
    trap_req = 1;
    irq_req = 1;
    out_ready = 1;
    step();
    trap_req = 0;
    irq_req = 0;
    out_ready = 0;
    settle();
    chk(out_addr == 7'h70, "R8", out_addr, 7'h70);
    step(); settle();
    chk(out_addr == a, "R8", out_addr, a);

    step();
    finish_run();
  end
endmodule